// File: doc/BRIEF.md
# DRAM Expansion Glue Controller

This block is the glue between the memory timing signals of an early 16-bit compact computer and a 4 MB expansion built from two banks of x16 DRAM. The host already produces a row strobe, two byte column strobes and a row/column phase clock for its onboard memory. The block adds two more multiplexed address bits, formed from the upper CPU address lines. It steers the host's byte strobes to one of the two expansion banks and makes an output enable for each bank. While the expansion is in use, it holds the onboard memory idle.

A held mouse button at reset turns the expansion off until the next reset. The machine then runs from its original memory, with the onboard strobes passed through unchanged. Everything apart from the enable flag is combinational, so the strobe edges pass through without any added clock latency.

Top module: `dram_expansion_glue`

## Requirements
- R1: `ra_ext[0]` carries `a_hi[0]` (A17) while `c2m` is high and `a_hi[1]` (A18) while `c2m` is low.
- R2: `ra_ext[1]` carries `a_hi[2]` (A19) while `c2m` is high and `a_hi[3]` (A20) while `c2m` is low.
- R3: When the expansion is enabled and `ras_n` is low, `a_hi[4]` (A21) selects the bank. A value of 0 sends `cas_n[1:0]` to `xcas_n[1:0]` (bank 0, bits lower/upper byte). A value of 1 sends them to `xcas_n[3:2]` (bank 1). The strobes of the other bank stay high.
- R4: No bit of `xcas_n` is low while `ras_n` is high. While enabled, `xras_n` follows `ras_n`.
- R5: `xoe_n[b]` is low exactly when at least one of bank b's two column strobes is low.
- R6: While the expansion is enabled, `ob_ras_n` and both bits of `ob_cas_n` are held high.
- R7: If `mouse_n` (active low) is held low when reset is released, the expansion is disabled. In that state `xcas_n` is 4'hF, `xoe_n` is 2'b11 and `xras_n` is high. `ob_ras_n` equals `ras_n` and `ob_cas_n` equals `cas_n`.
- R8: A reset released with `mouse_n` high enables the expansion, even if the previous reset left it disabled.
- R9: After reset release, later changes of `mouse_n` have no effect on the enable state until the next reset.
- R10: While `rst_n` is low, the block behaves as disabled: the onboard strobes pass through and the expansion strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mouse_n | input | 1 | Mouse button, low when pressed (asynchronous) |
| ras_n | input | 1 | Host row address strobe |
| cas_n | input | 2 | Host byte column strobes (bit 0 lower, bit 1 upper) |
| c2m | input | 1 | Row/column phase clock |
| a_hi | input | 5 | CPU address bits A17..A21 (bit 0 = A17) |
| ra_ext | output | 2 | Extra multiplexed DRAM address bits RA8, RA9 |
| xras_n | output | 1 | Row strobe to both expansion banks |
| xcas_n | output | 4 | Expansion column strobes: bank 0 lo/hi, bank 1 lo/hi |
| xoe_n | output | 2 | Expansion output enable per bank |
| ob_ras_n | output | 1 | Row strobe to onboard memory |
| ob_cas_n | output | 2 | Column strobes to onboard memory |

## Verification
On every cycle the assertions check four rules. No expansion column strobe is low while the row strobe is high. The two banks are never strobed at once. The enabled state keeps the onboard strobes high and the disabled state keeps the expansion strobes high. The enable flag never changes between resets. The address multiplexing, the bank steering and the output-enable values appear only in the bench's exhaustive sweep of all input combinations in both modes. The latching of the button at reset release, and its later immunity to button changes, appear only in the bench's reset scenarios.

// File: rtl/dram_expansion_glue.sv
module dram_expansion_glue #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mouse_n,
  input  logic       ras_n,
  input  logic [1:0] cas_n,
  input  logic       c2m,
  input  logic [4:0] a_hi,
  output logic [1:0] ra_ext,
  output logic       xras_n,
  output logic [3:0] xcas_n,
  output logic [1:0] xoe_n,
  output logic       ob_ras_n,
  output logic [1:0] ob_cas_n
);

  logic [SYNC_STAGES-1:0] msync;
  logic released;
  logic exp_en;
  logic live;
  logic bank_sel;

  always_ff @(posedge clk)
    msync <= {msync[SYNC_STAGES-2:0], mouse_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released <= 1'b0;
      exp_en   <= 1'b0;
    end else begin
      released <= 1'b1;
      if (!released) exp_en <= msync[SYNC_STAGES-1];
    end
  end

  assign ra_ext[0] = c2m ? a_hi[0] : a_hi[1];
  assign ra_ext[1] = c2m ? a_hi[2] : a_hi[3];

  assign bank_sel = a_hi[4];
  assign live     = exp_en & ~ras_n;

  assign xcas_n[1:0] = (live & ~bank_sel) ? cas_n : 2'b11;
  assign xcas_n[3:2] = (live &  bank_sel) ? cas_n : 2'b11;
  assign xoe_n[0]    = &xcas_n[1:0];
  assign xoe_n[1]    = &xcas_n[3:2];
  assign xras_n      = exp_en ? ras_n : 1'b1;

  assign ob_ras_n = exp_en ? 1'b1  : ras_n;
  assign ob_cas_n = exp_en ? 2'b11 : cas_n;

  assert_no_cas_without_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> (xcas_n == 4'hF));

  assert_single_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((xcas_n[1:0] != 2'b11) && (xcas_n[3:2] != 2'b11)));

  assert_onboard_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exp_en |-> (ob_ras_n && ob_cas_n == 2'b11));

  assert_expansion_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exp_en |-> (xcas_n == 4'hF && xoe_n == 2'b11 && xras_n));

  assert_flag_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (released && $past(released)) |-> $stable(exp_en));

endmodule

// File: tb/test_dram_expansion_glue.sv
module test_dram_expansion_glue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mouse_n = 1'b1;
  logic ras_n = 1'b1;
  logic [1:0] cas_n = 2'b11;
  logic c2m = 1'b0;
  logic [4:0] a_hi = '0;
  logic [1:0] ra_ext;
  logic xras_n;
  logic [3:0] xcas_n;
  logic [1:0] xoe_n;
  logic ob_ras_n;
  logic [1:0] ob_cas_n;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dram_expansion_glue i_dram_expansion_glue (
    .clk(clk), .rst_n(rst_n), .mouse_n(mouse_n), .ras_n(ras_n), .cas_n(cas_n),
    .c2m(c2m), .a_hi(a_hi), .ra_ext(ra_ext), .xras_n(xras_n), .xcas_n(xcas_n),
    .xoe_n(xoe_n), .ob_ras_n(ob_ras_n), .ob_cas_n(ob_cas_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep(input bit en, input string tag);
    for (int v = 0; v < 512; v++) begin
      logic [3:0] ecas;
      logic ok;
      @(negedge clk);
      {a_hi, c2m, cas_n, ras_n} = 9'(v);
      #1;
      chk({tag, " R1"}, {7'd0, ra_ext[0]}, {7'd0, c2m ? a_hi[0] : a_hi[1]});
      chk({tag, " R2"}, {7'd0, ra_ext[1]}, {7'd0, c2m ? a_hi[2] : a_hi[3]});
      ok = en && !ras_n;
      ecas = 4'hF;
      if (ok && !a_hi[4]) ecas[1:0] = cas_n;
      if (ok &&  a_hi[4]) ecas[3:2] = cas_n;
      chk({tag, " R3"}, {4'd0, xcas_n}, {4'd0, ecas});
      if (ras_n) chk({tag, " R4"}, {4'd0, xcas_n}, 8'h0F);
      chk({tag, " R4 xras"}, {7'd0, xras_n}, {7'd0, en ? ras_n : 1'b1});
      chk({tag, " R5"}, {6'd0, xoe_n},
          {6'd0, (ecas[3:2] != 2'b11) ? 1'b0 : 1'b1, (ecas[1:0] != 2'b11) ? 1'b0 : 1'b1});
      if (en) chk({tag, " R6"}, {5'd0, ob_ras_n, ob_cas_n}, 8'h07);
      else    chk({tag, " R7"}, {5'd0, ob_ras_n, ob_cas_n}, {5'd0, ras_n, cas_n});
    end
  endtask

  task automatic do_reset(input bit pressed);
    @(negedge clk);
    rst_n = 1'b0;
    mouse_n = ~pressed;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mouse_n = pressed;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mouse_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ras_n = 1'b0; cas_n = 2'b01; a_hi = 5'b00000;
    #1;
    chk("R10 reset xcas", {4'd0, xcas_n}, 8'h0F);
    chk("R10 reset passthrough", {5'd0, ob_ras_n, ob_cas_n}, 8'h01);
    sweep(1'b0, "R10 in reset");

    do_reset(1'b0);
    sweep(1'b1, "enabled");
    do_reset(1'b1);
    sweep(1'b0, "R7 disabled");
    repeat (5) @(posedge clk);
    sweep(1'b0, "R9 after release");
    do_reset(1'b0);
    sweep(1'b1, "R8 re-enabled");
    repeat (5) @(posedge clk);
    sweep(1'b1, "R9 press ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule